// File: doc/BRIEF.md
# Pipelined Accumulator Processor Core

This block is a small in-order processor whose single data register is an accumulator. Programs are built from memory-operand arithmetic (load, add, subtract, multiply), a store, an add of an immediate literal, four conditional branches that look at the accumulator's sign and zero state, a halt, and a no-operation. The pipeline has four stages. Fetch reads the instruction word and steps the PC by 4. A merged decode and data-memory stage reads the operand word or writes the store value. Execute combines the accumulator with the operand and evaluates the branch condition. Writeback updates the accumulator and, for a taken branch, steers the PC.

Instruction and data storage are small word arrays inside the core. The environment fills them through write ports while the core is held in reset. It then releases reset and waits for the halt flag. The final accumulator, the PC and any data word can then be read out through the debug outputs.

The program sees no pipeline timing. Results travel forward from execute and writeback to younger instructions. A store that sits behind a branch which has not yet resolved waits. A taken branch turns every younger instruction into a bubble.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted and right after it is released, `dbg_pc` is 0, `dbg_acc` is 0 and `halted` is 0, and no pipeline stage holds a valid instruction.
- R2: An instruction word carries its opcode in bits [31:27] and a signed 16-bit field in bits [15:0]. Opcodes are: 0 no-op, 1 load, 2 store, 3 add, 4 subtract, 5 multiply, 6 add-immediate, 8 branch-if-zero, 9 branch-if-nonzero, 10 branch-if-negative, 11 branch-if-positive, 31 halt. Any other opcode behaves as a no-op.
- R3: Load, add, subtract and multiply use the data word indexed by the low address bits of the field. They set the accumulator to that word, to the sum, to the accumulator minus the word, or to the low 32 bits of the product. The accumulator changes only when such an instruction, or an add-immediate, completes writeback.
- R4: Add-immediate adds the sign-extended 16-bit field to the accumulator.
- R5: A store writes to the indexed data word the accumulator value left by all older instructions.
- R6: Each instruction sees the results of all older instructions, even when they directly precede it.
- R7: Branch conditions are evaluated on the accumulator left by all older instructions. Branch-if-zero tests acc == 0, branch-if-nonzero tests acc != 0, branch-if-negative tests signed acc < 0, and branch-if-positive tests signed acc > 0.
- R8: The PC is a byte address that advances by 4 per fetch. A taken branch at address A continues at A + 4 + 4·field.
- R9: Instructions younger than a taken branch have no effect on the accumulator or on data memory.
- R10: A store that follows a branch which is still in execute or writeback waits until that branch leaves writeback. The store writes only if the branch was not taken.
- R11: Nothing after a halt instruction executes. `halted` rises once the halt reaches writeback and stays high until reset. The PC then holds at the halt's address + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Write enable for the instruction array |
| prog_addr | input | IAW | Instruction word index to write |
| prog_data | input | 32 | Instruction word to write |
| data_we | input | 1 | Loader write enable for the data array (overrides core stores) |
| data_addr | input | DAW | Data word index to write |
| data_wdata | input | 32 | Data word to write |
| peek_addr | input | DAW | Data word index for debug read-out |
| peek_data | output | 32 | Data word at `peek_addr` |
| halted | output | 1 | Sticky halt flag |
| dbg_acc | output | 32 | Current accumulator |
| dbg_pc | output | 32 | Current fetch PC |

## Verification
The memory-operand arithmetic is driven with a sweep of operand sets that includes zero, negative and overflowing multipliers and negative literals. Every instruction there depends on the one just before it, so a stale accumulator read gives a visibly wrong sum or product. A store-heavy program puts stores directly behind a load and behind an add-immediate, which separates the execute-stage forward from the writeback-stage forward. It also places unlisted opcodes in the stream.

All four branch kinds run against zero, small positive, small negative and the two signed extremes. Each branch skips a store that sits in its shadow, so the taken and not-taken paths differ in both the accumulator and a sentinel word. A counted backward loop and a store placed after the halt cover target arithmetic with a negative field and the end of fetch.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam logic [4:0] OP_NOP   = 5'd0;
    localparam logic [4:0] OP_LOAD  = 5'd1;
    localparam logic [4:0] OP_STORE = 5'd2;
    localparam logic [4:0] OP_ADD   = 5'd3;
    localparam logic [4:0] OP_SUB   = 5'd4;
    localparam logic [4:0] OP_MUL   = 5'd5;
    localparam logic [4:0] OP_ADDI  = 5'd6;
    localparam logic [4:0] OP_BZ    = 5'd8;
    localparam logic [4:0] OP_BNZ   = 5'd9;
    localparam logic [4:0] OP_BNEG  = 5'd10;
    localparam logic [4:0] OP_BPOS  = 5'd11;
    localparam logic [4:0] OP_HALT  = 5'd31;

    // fetch -> decode/memory
    typedef struct packed {
        logic        valid;
        logic [31:0] pc;
        logic [31:0] instr;
    } fd_t;

    // decode/memory -> execute
    typedef struct packed {
        logic        valid;
        logic [4:0]  op;
        logic [31:0] imm;
        logic [31:0] pc;
        logic [31:0] mdata;
    } dx_t;

    // execute -> writeback
    typedef struct packed {
        logic        valid;
        logic        wr;
        logic [31:0] res;
        logic        taken;
        logic        is_br;
        logic        is_halt;
        logic [31:0] target;
    } xw_t;

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] acc;
        logic        halt;
        logic        stop;
        fd_t         fd;
        dx_t         dx;
        xw_t         xw;
    } core_t;

    function automatic logic is_branch(logic [4:0] op);
        return (op == OP_BZ) || (op == OP_BNZ) || (op == OP_BNEG) || (op == OP_BPOS);
    endfunction

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter  int WORDS = 32,
    parameter  int W     = 32,
    parameter  int NRD   = 1,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata
);
    logic [W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem_q[raddr[g]];
    end
endmodule

// File: rtl/acc_exec.sv
module acc_exec
    import acc_pkg::*;
(
    input  logic [4:0]  op,
    input  logic [31:0] acc_in,
    input  logic [31:0] mem_in,
    input  logic [31:0] lit,
    output logic [31:0] res,
    output logic        wr,
    output logic        cond
);
    logic [31:0] prod;
    assign prod = acc_in * mem_in;

    always_comb begin
        res = acc_in;
        wr  = 1'b1;
        unique case (op)
            OP_LOAD: res = mem_in;
            OP_ADD:  res = acc_in + mem_in;
            OP_SUB:  res = acc_in - mem_in;
            OP_MUL:  res = prod;
            OP_ADDI: res = acc_in + lit;
            default: wr  = 1'b0;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_BZ:   cond = (acc_in == '0);
            OP_BNZ:  cond = (acc_in != '0);
            OP_BNEG: cond = acc_in[31];
            OP_BPOS: cond = !acc_in[31] && (acc_in != '0);
            default: cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter  int IMEM_WORDS = 32,
    parameter  int DMEM_WORDS = 32,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prog_we,
    input  logic [IAW-1:0] prog_addr,
    input  logic [31:0]    prog_data,
    input  logic           data_we,
    input  logic [DAW-1:0] data_addr,
    input  logic [31:0]    data_wdata,
    input  logic [DAW-1:0] peek_addr,
    output logic [31:0]    peek_data,
    output logic           halted,
    output logic [31:0]    dbg_acc,
    output logic [31:0]    dbg_pc
);
    core_t st_d, st_q;

    logic [0:0][IAW-1:0] imem_ra;
    logic [0:0][31:0]    imem_rd;
    logic [1:0][DAW-1:0] dmem_ra;
    logic [1:0][31:0]    dmem_rd;
    logic                dm_we;
    logic [DAW-1:0]      dm_wa;
    logic [31:0]         dm_wd;

    logic [31:0] acc_ex, ex_res;
    logic        ex_wr_raw, ex_cond;
    logic [4:0]  dm_op;
    logic        flush, stall, dm_halt, fetch_en, core_we;
    logic        dx_br, xw_br;
    logic [31:0] st_val;

    assign imem_ra[0] = st_q.pc[IAW+1:2];
    assign dmem_ra[0] = st_q.fd.instr[DAW-1:0];
    assign dmem_ra[1] = peek_addr;

    acc_mem #(.WORDS(IMEM_WORDS), .W(32), .NRD(1)) u_imem (
        .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
        .raddr(imem_ra), .rdata(imem_rd)
    );

    acc_mem #(.WORDS(DMEM_WORDS), .W(32), .NRD(2)) u_dmem (
        .clk(clk), .we(dm_we), .waddr(dm_wa), .wdata(dm_wd),
        .raddr(dmem_ra), .rdata(dmem_rd)
    );

    // accumulator seen by execute: writeback result overrides the register
    assign acc_ex = (st_q.xw.valid && st_q.xw.wr) ? st_q.xw.res : st_q.acc;

    acc_exec u_exec (
        .op(st_q.dx.op), .acc_in(acc_ex), .mem_in(st_q.dx.mdata), .lit(st_q.dx.imm),
        .res(ex_res), .wr(ex_wr_raw), .cond(ex_cond)
    );

    always_comb begin
        dm_op    = st_q.fd.instr[31:27];
        flush    = st_q.xw.valid && st_q.xw.taken;
        dx_br    = st_q.dx.valid && is_branch(st_q.dx.op);
        xw_br    = st_q.xw.valid && st_q.xw.is_br;
        stall    = st_q.fd.valid && (dm_op == OP_STORE) && (dx_br || xw_br);
        core_we  = st_q.fd.valid && (dm_op == OP_STORE) && !stall && !flush;
        dm_halt  = st_q.fd.valid && (dm_op == OP_HALT) && !flush;
        fetch_en = !st_q.stop && !st_q.halt && !dm_halt && !stall;
        st_val   = (st_q.dx.valid && ex_wr_raw) ? ex_res : acc_ex;

        dm_we = data_we || core_we;
        dm_wa = data_we ? data_addr  : st_q.fd.instr[DAW-1:0];
        dm_wd = data_we ? data_wdata : st_val;

        st_d = st_q;

        // writeback
        if (st_q.xw.valid && st_q.xw.wr) st_d.acc = st_q.xw.res;
        if (st_q.xw.valid && st_q.xw.is_halt) st_d.halt = 1'b1;
        st_d.stop = flush ? 1'b0 : (st_q.stop || dm_halt);

        // fetch
        if (flush)         st_d.pc = st_q.xw.target;
        else if (fetch_en) st_d.pc = st_q.pc + 32'd4;

        if (flush)         st_d.fd = '0;
        else if (stall)    st_d.fd = st_q.fd;
        else if (fetch_en) st_d.fd = '{valid: 1'b1, pc: st_q.pc, instr: imem_rd[0]};
        else               st_d.fd = '0;

        // decode / memory -> execute
        if (flush || stall) st_d.dx = '0;
        else st_d.dx = '{valid: st_q.fd.valid, op: dm_op,
                         imm: {{16{st_q.fd.instr[15]}}, st_q.fd.instr[15:0]},
                         pc: st_q.fd.pc, mdata: dmem_rd[0]};

        // execute -> writeback
        if (flush) st_d.xw = '0;
        else st_d.xw = '{valid: st_q.dx.valid,
                         wr: st_q.dx.valid && ex_wr_raw,
                         res: ex_res,
                         taken: st_q.dx.valid && is_branch(st_q.dx.op) && ex_cond,
                         is_br: st_q.dx.valid && is_branch(st_q.dx.op),
                         is_halt: st_q.dx.valid && (st_q.dx.op == OP_HALT),
                         target: st_q.dx.pc + 32'd4 + {st_q.dx.imm[29:0], 2'b00}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign peek_data = dmem_rd[1];
    assign halted    = st_q.halt;
    assign dbg_acc   = st_q.acc;
    assign dbg_pc    = st_q.pc;

    logic unused_bits;
    assign unused_bits = ^{st_q.fd.instr[26:16], st_q.pc[31:IAW+2], st_q.pc[1:0]};

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.xw.valid && st_q.xw.wr) |=> $stable(st_q.acc));

    // R8
    branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.xw.valid && st_q.xw.taken) |=> (st_q.pc == $past(st_q.xw.target)));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.xw.valid && st_q.xw.taken) |=> (!st_q.fd.valid && !st_q.dx.valid && !st_q.xw.valid));

    // R10
    store_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |-> !(st_q.dx.valid && is_branch(st_q.dx.op)) && !(st_q.xw.valid && st_q.xw.is_br));

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halt |=> (st_q.halt && $stable(st_q.pc) && $stable(st_q.acc)));

    // R11
    halt_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halt |-> !st_q.fd.valid && !st_q.dx.valid);
endmodule

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb;
    localparam int IAW = 5;
    localparam int DAW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_we = 1'b0;
    logic [IAW-1:0] prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic data_we = 1'b0;
    logic [DAW-1:0] data_addr = '0;
    logic [31:0] data_wdata = '0;
    logic [DAW-1:0] peek_addr = '0;
    logic [31:0] peek_data, dbg_acc, dbg_pc;
    logic halted;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [31:0] prog [32];
    logic [31:0] dini [32];

    always #4 clk = ~clk;

    acc_core #(.IMEM_WORDS(32), .DMEM_WORDS(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .data_we(data_we), .data_addr(data_addr),
        .data_wdata(data_wdata), .peek_addr(peek_addr), .peek_data(peek_data),
        .halted(halted), .dbg_acc(dbg_acc), .dbg_pc(dbg_pc)
    );

    function automatic logic [31:0] enc(logic [4:0] op, logic [15:0] f);
        return {op, 11'd0, f};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input int a, output logic [31:0] v);
        peek_addr = a[DAW-1:0];
        #1;
        v = peek_data;
    endtask

    // load arrays under reset, release, run to halt
    task automatic run_prog(input int limit);
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        // R1
        chk("R1 reset pc", dbg_pc, 32'd0);
        chk("R1 reset acc", dbg_acc, 32'd0);
        chk("R1 reset halted", {31'd0, halted}, 32'd0);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = i[IAW-1:0]; prog_data = prog[i];
            data_we = 1'b1; data_addr = i[DAW-1:0]; data_wdata = dini[i];
        end
        @(negedge clk);
        prog_we = 1'b0; data_we = 1'b0;
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (!halted) chk("R11 halt reached", 32'd0, 32'd1);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 32; i++) begin
            prog[i] = 32'd0;
            dini[i] = 32'hDEAD_0000 + i;
        end
    endtask

    initial begin
        logic [31:0] a, b, c, d, v, exp, got;
        logic [15:0] k;
        logic [4:0] bop;
        logic take;

        // R3 R4 R6 R11: dependent arithmetic chain, operand sweep
        for (int s = 0; s < 8; s++) begin
            clear_all();
            a = s * 32'h0101_0101 - 32'd7;
            b = 32'h7FFF_FFF0 + s;
            c = -(s * 3);
            d = s - 4;
            k = 16'(s * 5000 - 20000);
            dini[26] = a; dini[27] = b; dini[28] = c; dini[29] = d;
            prog[0] = enc(5'd1, 16'd26);
            prog[1] = enc(5'd3, 16'd27);
            prog[2] = enc(5'd4, 16'd28);
            prog[3] = enc(5'd5, 16'd29);
            prog[4] = enc(5'd6, k);
            prog[5] = enc(5'd2, 16'd20);
            prog[6] = enc(5'd31, 16'd0);
            prog[7] = enc(5'd2, 16'd19);
            prog[8] = enc(5'd6, 16'd1);
            run_prog(200);
            exp = (a + b - c) * d + {{16{k[15]}}, k};
            chk("R3 R4 R6 chain acc", dbg_acc, exp);
            peek(20, got);
            chk("R5 chain store", got, exp);
            peek(19, got);
            chk("R11 store after halt", got, 32'hDEAD_0013);
            chk("R11 halt pc", dbg_pc, 32'd28);
        end

        // R5 R6 R2: stores right behind producers, unlisted opcodes
        clear_all();
        v = 32'hFFFF_FF80;
        dini[31] = v;
        prog[0] = enc(5'd1, 16'd31);
        prog[1] = enc(5'd2, 16'd21);
        prog[2] = enc(5'd6, 16'd5);
        prog[3] = enc(5'd0, 16'd0);
        prog[4] = enc(5'd7, 16'd99);
        prog[5] = enc(5'd2, 16'd22);
        prog[6] = enc(5'd6, 16'hFFFD);
        prog[7] = enc(5'd2, 16'd20);
        prog[8] = enc(5'd12, 16'd21);
        prog[9] = enc(5'd31, 16'd0);
        run_prog(200);
        peek(21, got);
        chk("R5 R6 store after load", got, v);
        peek(22, got);
        chk("R2 R6 store after addi and unlisted ops", got, v + 32'd5);
        peek(20, got);
        chk("R5 store after negative addi", got, v + 32'd2);
        chk("R2 final acc", dbg_acc, v + 32'd2);
        chk("R11 halt pc", dbg_pc, 32'd40);

        // R7 R8 R9 R10: every branch kind against sign corner values
        for (int bi = 0; bi < 4; bi++) begin
            for (int vi = 0; vi < 5; vi++) begin
                clear_all();
                case (vi)
                    0: v = 32'd0;
                    1: v = 32'd7;
                    2: v = 32'hFFFF_FFF9;
                    3: v = 32'h7FFF_FFFF;
                    default: v = 32'h8000_0000;
                endcase
                bop = 5'(8 + bi);
                case (bi)
                    0: take = (v == 0);
                    1: take = (v != 0);
                    2: take = v[31];
                    default: take = !v[31] && (v != 0);
                endcase
                dini[30] = v;
                prog[0] = enc(5'd1, 16'd30);
                prog[1] = enc(bop, 16'd2);
                prog[2] = enc(5'd2, 16'd24);
                prog[3] = enc(5'd6, 16'd2);
                prog[4] = enc(5'd6, 16'd100);
                prog[5] = enc(5'd2, 16'd23);
                prog[6] = enc(5'd31, 16'd0);
                run_prog(200);
                exp = take ? v + 32'd100 : v + 32'd102;
                chk("R7 R8 branch acc", dbg_acc, exp);
                peek(24, got);
                chk("R9 R10 shadow store", got, take ? 32'hDEAD_0018 : v);
                peek(23, got);
                chk("R8 landing store", got, exp);
            end
        end

        // R8: counted backward loop with negative field
        clear_all();
        dini[30] = 32'd5;
        prog[0] = enc(5'd1, 16'd30);
        prog[1] = enc(5'd6, 16'hFFFF);
        prog[2] = enc(5'd9, 16'hFFFE);
        prog[3] = enc(5'd2, 16'd25);
        prog[4] = enc(5'd31, 16'd0);
        run_prog(400);
        chk("R8 loop acc", dbg_acc, 32'd0);
        peek(25, got);
        chk("R8 loop exit store", got, 32'd0);
        chk("R8 R11 loop halt pc", dbg_pc, 32'd20);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule